// File: doc/BRIEF.md
# I/O Controller Status and Acknowledge Register Bank

This block is a small register bank inside an I/O controller. A host reads and writes it over a simple request/response register bus. Reads return several kinds of value. Module presence is built from one presence input per slot and reported active-low. A board platform code is returned, along with fixed flash and environment status words. One 8-bit I/O mask register can be written and read back. Two of the read addresses also acknowledge an interrupt: reading them drops the matching pending line (management or external). Every other address reads as zero.

Two board variants are supported, chosen by parameter. The narrow variant has four slots and one presence word, in which each present slot clears one bit in every nibble. The wide variant has six slots spread over two presence words, and each present slot clears a whole nibble through its own mask. The two variants also place the acknowledge registers at different offsets.

Requests use valid/ready. `req_ready` falls only while a response is waiting and `rsp_ready` is low. Once accepted, each request produces exactly one response beat on the next cycle. That beat holds its data until `rsp_ready` is seen high.

Top module: `iofc_status_regs`

## Requirements
- R1: After reset, `rsp_valid`, `mgmt_irq` and `ext_irq` are 0 and the I/O mask reads 0.
- R2: Narrow variant, offset 0x10006: the read starts from 0xFFFF, and each present slot i (0..3) clears the bits 0x1111 << i.
- R3: Wide variant: offset 0x10006 starts at 0xFFFF and ANDs in the masks of present slots 1..4 (0xF0FF, 0xFFF0, 0x0FFF, 0xFF0F). Offset 0x10008 does the same for slots 5 and 6 (0xF0FF, 0xFFF0). Slot 0 affects neither word.
- R4: Offset 0x30000 returns the platform code in bits 7:5, with all other bits 0. The code is the `BOARD_CODE` parameter on the narrow variant and 3 on the wide variant.
- R5: Offset 0x08 reads 0x00FF, offset 0x0A reads 0x1000 and offset 0x30004 reads 0x0021, on both variants.
- R6: Offset 0x20008 holds an 8-bit mask. A write stores `req_wdata[7:0]`, and a read returns it zero-extended.
- R7: A pulse on `mgmt_event` sets `mgmt_irq` on the next cycle. An accepted read of the management acknowledge offset (0x20004 narrow, 0x10014 wide) returns 0 and clears `mgmt_irq` on the next cycle.
- R8: A pulse on `ext_event` sets `ext_irq` on the next cycle. An accepted read of the external acknowledge offset (0x20006 narrow, 0x2000A wide) clears `ext_irq` on the next cycle. That read returns 0 on the narrow variant and 0x0054 on the wide one.
- R9: When an event and an acknowledge read of the same line fall in the same cycle, the line stays set.
- R10: A write to an acknowledge offset leaves the pending line unchanged.
- R11: Reads of unmapped offsets return 0. Writes to read-only or unmapped offsets change nothing. A write's response beat carries 0.
- R12: While `rsp_valid` is high and `rsp_ready` is low, `req_ready` is low and `rsp_rdata` holds. A request is accepted on a cycle where both `req_valid` and `req_ready` are high, and its response appears on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slot_present | input | NUM_SLOTS | Per-slot module presence, 1 = present |
| mgmt_event | input | 1 | Management interrupt event pulse |
| ext_event | input | 1 | External interrupt event pulse |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Register offset |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Response beat valid |
| rsp_ready | input | 1 | Host takes the response |
| rsp_rdata | output | DATA_W | Read data (0 for writes) |
| mgmt_irq | output | 1 | Pending management interrupt |
| ext_irq | output | 1 | Pending external interrupt |

## Verification
Two functions can fall in one cycle: a new interrupt event, and an accepted read of that line's acknowledge offset. The bench provokes this by driving the event pulse and the acknowledge read on the same clock, once for each line and on both variants. It judges the result against a behavioural model in which the set wins: the read still returns its acknowledge value, and the pending line is still high afterwards. The model is checked against the line on every clock.

// File: rtl/iofc_pkg.sv
package iofc_pkg;

  typedef enum logic [3:0] {
    SEL_NONE,
    SEL_FLASH_PROT,
    SEL_FLASH_SIZE,
    SEL_PRES_LO,
    SEL_PRES_HI,
    SEL_MGMT_ACK,
    SEL_EXT_ACK,
    SEL_IOMASK,
    SEL_PLATFORM,
    SEL_ENV
  } iofc_sel_e;

  // Shared offsets
  localparam logic [31:0] OFF_FLASH_PROT = 32'h0000_0008;
  localparam logic [31:0] OFF_FLASH_SIZE = 32'h0000_000A;
  localparam logic [31:0] OFF_PRES_LO    = 32'h0001_0006;
  localparam logic [31:0] OFF_PRES_HI    = 32'h0001_0008;
  localparam logic [31:0] OFF_IOMASK     = 32'h0002_0008;
  localparam logic [31:0] OFF_PLATFORM   = 32'h0003_0000;
  localparam logic [31:0] OFF_ENV        = 32'h0003_0004;

  // Variant-dependent acknowledge offsets
  localparam logic [31:0] OFF_MGMT_ACK_N = 32'h0002_0004;
  localparam logic [31:0] OFF_EXT_ACK_N  = 32'h0002_0006;
  localparam logic [31:0] OFF_MGMT_ACK_W = 32'h0001_0014;
  localparam logic [31:0] OFF_EXT_ACK_W  = 32'h0002_000A;

  // Fixed read values
  localparam logic [15:0] VAL_FLASH_PROT = 16'h00FF;
  localparam logic [15:0] VAL_FLASH_SIZE = 16'h1000;
  localparam logic [15:0] VAL_ENV        = 16'h0021;
  localparam logic [15:0] VAL_EXT_ACK_W  = 16'h0054;

  localparam logic [2:0]  PLAT_CODE_W    = 3'd3;
  localparam int unsigned PLAT_SHIFT     = 5;
  localparam int unsigned IOMASK_W       = 8;
  localparam int unsigned NARROW_SLOTS   = 4;

  function automatic logic [31:0] mgmt_ack_off(input bit wide);
    return wide ? OFF_MGMT_ACK_W : OFF_MGMT_ACK_N;
  endfunction

  function automatic logic [31:0] ext_ack_off(input bit wide);
    return wide ? OFF_EXT_ACK_W : OFF_EXT_ACK_N;
  endfunction

  // Nibble-clear mask contributed by a present slot on the wide variant
  function automatic logic [15:0] wide_slot_mask(input int unsigned slot);
    case (slot)
      1, 5:    return 16'hF0FF;
      2, 6:    return 16'hFFF0;
      3:       return 16'h0FFF;
      4:       return 16'hFF0F;
      default: return 16'hFFFF;
    endcase
  endfunction

endpackage

// File: rtl/iofc_decode.sv
module iofc_decode
  import iofc_pkg::*;
#(
  parameter bit          VARIANT_B = 1'b0,
  parameter int unsigned ADDR_W    = 18
) (
  input  logic [ADDR_W-1:0] addr,
  output iofc_sel_e         sel
);

  logic [31:0] a32;
  assign a32 = 32'(addr);

  generate
    if (VARIANT_B) begin : g_wide
      always_comb begin
        case (a32)
          OFF_FLASH_PROT: sel = SEL_FLASH_PROT;
          OFF_FLASH_SIZE: sel = SEL_FLASH_SIZE;
          OFF_PRES_LO:    sel = SEL_PRES_LO;
          OFF_PRES_HI:    sel = SEL_PRES_HI;
          OFF_MGMT_ACK_W: sel = SEL_MGMT_ACK;
          OFF_EXT_ACK_W:  sel = SEL_EXT_ACK;
          OFF_IOMASK:     sel = SEL_IOMASK;
          OFF_PLATFORM:   sel = SEL_PLATFORM;
          OFF_ENV:        sel = SEL_ENV;
          default:        sel = SEL_NONE;
        endcase
      end
    end else begin : g_narrow
      always_comb begin
        case (a32)
          OFF_FLASH_PROT: sel = SEL_FLASH_PROT;
          OFF_FLASH_SIZE: sel = SEL_FLASH_SIZE;
          OFF_PRES_LO:    sel = SEL_PRES_LO;
          OFF_MGMT_ACK_N: sel = SEL_MGMT_ACK;
          OFF_EXT_ACK_N:  sel = SEL_EXT_ACK;
          OFF_IOMASK:     sel = SEL_IOMASK;
          OFF_PLATFORM:   sel = SEL_PLATFORM;
          OFF_ENV:        sel = SEL_ENV;
          default:        sel = SEL_NONE;
        endcase
      end
    end
  endgenerate

endmodule

// File: rtl/iofc_presence.sv
module iofc_presence
  import iofc_pkg::*;
#(
  parameter bit          VARIANT_B = 1'b0,
  parameter int unsigned NUM_SLOTS = 7,
  parameter int unsigned DATA_W    = 16
) (
  input  logic [NUM_SLOTS-1:0] present,
  output logic [DATA_W-1:0]    word_lo,
  output logic [DATA_W-1:0]    word_hi
);

  localparam int unsigned LO_FIRST = 1;
  localparam int unsigned LO_LAST  = 4;
  localparam int unsigned HI_FIRST = 5;
  localparam int unsigned HI_LAST  = 6;

  generate
    if (VARIANT_B) begin : g_wide
      always_comb begin
        word_lo = '1;
        word_hi = '1;
        for (int unsigned s = LO_FIRST; s <= LO_LAST; s++) begin
          if (s < NUM_SLOTS && present[s])
            word_lo = word_lo & DATA_W'(wide_slot_mask(s));
        end
        for (int unsigned s = HI_FIRST; s <= HI_LAST; s++) begin
          if (s < NUM_SLOTS && present[s])
            word_hi = word_hi & DATA_W'(wide_slot_mask(s));
        end
      end
    end else begin : g_narrow
      always_comb begin
        word_lo = '1;
        for (int unsigned s = 0; s < NARROW_SLOTS; s++) begin
          if (s < NUM_SLOTS && present[s])
            word_lo = word_lo & ~(DATA_W'(16'h1111) << s);
        end
        word_hi = '0;
      end
    end
  endgenerate

endmodule

// File: rtl/iofc_irq_pending.sv
module iofc_irq_pending (
  input  logic clk,
  input  logic rst_n,
  input  logic event_i,
  input  logic ack_i,
  output logic pend_o
);

  // A fresh event outranks an acknowledge in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend_o <= 1'b0;
    else if (event_i) pend_o <= 1'b1;
    else if (ack_i)   pend_o <= 1'b0;
  end

endmodule

// File: rtl/iofc_status_regs.sv
module iofc_status_regs
  import iofc_pkg::*;
#(
  parameter bit          VARIANT_B  = 1'b0,
  parameter logic [2:0]  BOARD_CODE = 3'd0,
  parameter int unsigned ADDR_W     = 18,
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned NUM_SLOTS  = 7
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_SLOTS-1:0] slot_present,
  input  logic                 mgmt_event,
  input  logic                 ext_event,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic                 req_write,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [DATA_W-1:0]    req_wdata,
  output logic                 rsp_valid,
  input  logic                 rsp_ready,
  output logic [DATA_W-1:0]    rsp_rdata,
  output logic                 mgmt_irq,
  output logic                 ext_irq
);

  localparam int unsigned NUM_LINES = 2;
  localparam logic [2:0]  PLAT_CODE = VARIANT_B ? PLAT_CODE_W : BOARD_CODE;
  localparam logic [DATA_W-1:0] PLAT_WORD =
    DATA_W'({PLAT_CODE, {PLAT_SHIFT{1'b0}}});
  localparam logic [DATA_W-1:0] EXT_ACK_WORD =
    VARIANT_B ? DATA_W'(VAL_EXT_ACK_W) : '0;

  iofc_sel_e             sel;
  logic [DATA_W-1:0]     pres_lo;
  logic [DATA_W-1:0]     pres_hi;
  logic [DATA_W-1:0]     rd_mux;
  logic [IOMASK_W-1:0]   iomask_q;
  logic                  accept;
  logic                  rd_accept;
  logic [NUM_LINES-1:0]  line_event;
  logic [NUM_LINES-1:0]  line_ack;
  logic [NUM_LINES-1:0]  line_pend;

  iofc_decode #(
    .VARIANT_B (VARIANT_B),
    .ADDR_W    (ADDR_W)
  ) u_decode (
    .addr (req_addr),
    .sel  (sel)
  );

  iofc_presence #(
    .VARIANT_B (VARIANT_B),
    .NUM_SLOTS (NUM_SLOTS),
    .DATA_W    (DATA_W)
  ) u_presence (
    .present (slot_present),
    .word_lo (pres_lo),
    .word_hi (pres_hi)
  );

  // Handshake: stall only when a response is parked and not taken
  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;
  assign rd_accept = accept && !req_write;

  // Interrupt lines: index 0 management, index 1 external
  assign line_event = {ext_event, mgmt_event};
  assign line_ack   = {rd_accept && (sel == SEL_EXT_ACK),
                       rd_accept && (sel == SEL_MGMT_ACK)};

  generate
    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
      iofc_irq_pending u_pend (
        .clk     (clk),
        .rst_n   (rst_n),
        .event_i (line_event[g]),
        .ack_i   (line_ack[g]),
        .pend_o  (line_pend[g])
      );
    end
  endgenerate

  assign mgmt_irq = line_pend[0];
  assign ext_irq  = line_pend[1];

  always_comb begin
    case (sel)
      SEL_FLASH_PROT: rd_mux = DATA_W'(VAL_FLASH_PROT);
      SEL_FLASH_SIZE: rd_mux = DATA_W'(VAL_FLASH_SIZE);
      SEL_PRES_LO:    rd_mux = pres_lo;
      SEL_PRES_HI:    rd_mux = pres_hi;
      SEL_MGMT_ACK:   rd_mux = '0;
      SEL_EXT_ACK:    rd_mux = EXT_ACK_WORD;
      SEL_IOMASK:     rd_mux = DATA_W'(iomask_q);
      SEL_PLATFORM:   rd_mux = PLAT_WORD;
      SEL_ENV:        rd_mux = DATA_W'(VAL_ENV);
      default:        rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      iomask_q <= '0;
    end else if (accept && req_write && sel == SEL_IOMASK) begin
      iomask_q <= req_wdata[IOMASK_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else if (accept) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= req_write ? '0 : rd_mux;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/iofc_status_regs_chk.sv
module iofc_status_regs_chk
  import iofc_pkg::*;
#(
  parameter bit          VARIANT_B  = 1'b0,
  parameter logic [2:0]  BOARD_CODE = 3'd0,
  parameter int unsigned ADDR_W     = 18,
  parameter int unsigned DATA_W     = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic              mgmt_event,
  input logic              ext_event,
  input logic              mgmt_irq,
  input logic              ext_irq
);

  localparam logic [31:0] MGMT_OFF = mgmt_ack_off(VARIANT_B);
  localparam logic [31:0] EXT_OFF  = ext_ack_off(VARIANT_B);
  localparam logic [2:0]  EXP_CODE = VARIANT_B ? PLAT_CODE_W : BOARD_CODE;

  logic rd_take, mgmt_rd, ext_rd, plat_rd, mgmt_wr, ext_wr;
  assign rd_take = req_valid && req_ready && !req_write;
  assign mgmt_rd = rd_take && (32'(req_addr) == MGMT_OFF);
  assign ext_rd  = rd_take && (32'(req_addr) == EXT_OFF);
  assign plat_rd = rd_take && (32'(req_addr) == OFF_PLATFORM);
  assign mgmt_wr = req_valid && req_ready && req_write &&
                   (32'(req_addr) == MGMT_OFF);
  assign ext_wr  = req_valid && req_ready && req_write &&
                   (32'(req_addr) == EXT_OFF);

  assert_rsp_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));

  assert_stall_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);

  assert_accept_rsp_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid);

  assert_mgmt_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mgmt_event |=> mgmt_irq);

  assert_ext_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ext_event |=> ext_irq);

  assert_mgmt_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mgmt_rd && !mgmt_event) |=> (!mgmt_irq && rsp_rdata == '0));

  assert_ext_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_rd && !ext_event) |=> !ext_irq);

  assert_mgmt_wr_keep_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mgmt_irq && mgmt_wr) |=> mgmt_irq);

  assert_ext_wr_keep_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_irq && ext_wr) |=> ext_irq);

  assert_platform_R4: assert property (@(posedge clk) disable iff (!rst_n)
    plat_rd |=> (rsp_rdata[7:5] == EXP_CODE && rsp_rdata[4:0] == 5'd0));

endmodule

bind iofc_status_regs iofc_status_regs_chk #(
  .VARIANT_B  (VARIANT_B),
  .BOARD_CODE (BOARD_CODE),
  .ADDR_W     (ADDR_W),
  .DATA_W     (DATA_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_write  (req_write),
  .req_addr   (req_addr),
  .rsp_valid  (rsp_valid),
  .rsp_ready  (rsp_ready),
  .rsp_rdata  (rsp_rdata),
  .mgmt_event (mgmt_event),
  .ext_event  (ext_event),
  .mgmt_irq   (mgmt_irq),
  .ext_irq    (ext_irq)
);

// File: tb/iofc_status_regs_tb.sv
module iofc_status_regs_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // Index 0: narrow variant (board code 4), index 1: wide variant
  logic [6:0]  pres       [2];
  logic        mgmt_event [2];
  logic        ext_event  [2];
  logic        req_valid  [2];
  logic        req_ready  [2];
  logic        req_write  [2];
  logic [17:0] req_addr   [2];
  logic [15:0] req_wdata  [2];
  logic        rsp_valid  [2];
  logic        rsp_ready  [2];
  logic [15:0] rsp_rdata  [2];
  logic        mgmt_irq   [2];
  logic        ext_irq    [2];

  iofc_status_regs #(.VARIANT_B(1'b0), .BOARD_CODE(3'd4)) u_dut (
    .clk(clk), .rst_n(rst_n), .slot_present(pres[0]),
    .mgmt_event(mgmt_event[0]), .ext_event(ext_event[0]),
    .req_valid(req_valid[0]), .req_ready(req_ready[0]),
    .req_write(req_write[0]), .req_addr(req_addr[0]),
    .req_wdata(req_wdata[0]), .rsp_valid(rsp_valid[0]),
    .rsp_ready(rsp_ready[0]), .rsp_rdata(rsp_rdata[0]),
    .mgmt_irq(mgmt_irq[0]), .ext_irq(ext_irq[0]));

  iofc_status_regs #(.VARIANT_B(1'b1), .BOARD_CODE(3'd0)) u_dut_b (
    .clk(clk), .rst_n(rst_n), .slot_present(pres[1]),
    .mgmt_event(mgmt_event[1]), .ext_event(ext_event[1]),
    .req_valid(req_valid[1]), .req_ready(req_ready[1]),
    .req_write(req_write[1]), .req_addr(req_addr[1]),
    .req_wdata(req_wdata[1]), .rsp_valid(rsp_valid[1]),
    .rsp_ready(rsp_ready[1]), .rsp_rdata(rsp_rdata[1]),
    .mgmt_irq(mgmt_irq[1]), .ext_irq(ext_irq[1]));

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  // Behavioural reference state
  bit       m_mgmt [2];
  bit       m_ext  [2];
  bit       m_rv   [2];
  bit [7:0] m_mask [2];

  function automatic int mgmt_off(int v);
    return (v == 0) ? 'h20004 : 'h10014;
  endfunction
  function automatic int ext_off(int v);
    return (v == 0) ? 'h20006 : 'h2000A;
  endfunction

  function automatic logic [15:0] wide_mask(int s);
    logic [15:0] t [7] = '{16'hFFFF, 16'hF0FF, 16'hFFF0, 16'h0FFF,
                           16'hFF0F, 16'hF0FF, 16'hFFF0};
    return t[s];
  endfunction

  function automatic logic [15:0] exp_read(int v, int a);
    logic [15:0] w;
    w = 16'hFFFF;
    if (a == 'h8)     return 16'h00FF;
    if (a == 'hA)     return 16'h1000;
    if (a == 'h30004) return 16'h0021;
    if (a == 'h20008) return {8'h00, m_mask[v]};
    if (a == 'h30000) return (v == 0) ? 16'h0080 : 16'h0060;
    if (a == mgmt_off(v)) return 16'h0000;
    if (a == ext_off(v))  return (v == 0) ? 16'h0000 : 16'h0054;
    if (v == 0) begin
      if (a == 'h10006) begin
        for (int i = 0; i < 4; i++)
          if (pres[0][i]) w &= ~(16'h1111 << i);
        return w;
      end
    end else begin
      if (a == 'h10006) begin
        for (int s = 1; s <= 4; s++) if (pres[1][s]) w &= wide_mask(s);
        return w;
      end
      if (a == 'h10008) begin
        for (int s = 5; s <= 6; s++) if (pres[1][s]) w &= wide_mask(s);
        return w;
      end
    end
    return 16'h0000;
  endfunction

  task automatic check(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // Reference model, advanced on each rising edge from bench-driven inputs
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int v = 0; v < 2; v++) begin
        m_mgmt[v] = 0; m_ext[v] = 0; m_rv[v] = 0; m_mask[v] = 0;
      end
    end else begin
      for (int v = 0; v < 2; v++) begin
        bit acc;
        acc = req_valid[v] && (!m_rv[v] || rsp_ready[v]);
        if (acc && !req_write[v] && int'(req_addr[v]) == mgmt_off(v)) m_mgmt[v] = 0;
        if (acc && !req_write[v] && int'(req_addr[v]) == ext_off(v))  m_ext[v]  = 0;
        if (mgmt_event[v]) m_mgmt[v] = 1;
        if (ext_event[v])  m_ext[v]  = 1;
        if (acc && req_write[v] && int'(req_addr[v]) == 'h20008)
          m_mask[v] = req_wdata[v][7:0];
        m_rv[v] = acc ? 1'b1 : (rsp_ready[v] ? 1'b0 : m_rv[v]);
      end
    end
  end

  // Every-clock comparison of the pending lines and the handshake
  always @(negedge clk) begin
    if (rst_n && !done) begin
      for (int v = 0; v < 2; v++) begin
        check(mgmt_irq[v] == m_mgmt[v], "R7 mgmt_irq", 32'(mgmt_irq[v]), 32'(m_mgmt[v]));
        check(ext_irq[v] == m_ext[v], "R8 ext_irq", 32'(ext_irq[v]), 32'(m_ext[v]));
        check(rsp_valid[v] == m_rv[v], "R12 rsp_valid", 32'(rsp_valid[v]), 32'(m_rv[v]));
        check(req_ready[v] == (!m_rv[v] || rsp_ready[v]), "R12 req_ready",
              32'(req_ready[v]), 32'(!m_rv[v] || rsp_ready[v]));
      end
    end
  end

  task automatic rd(input int v, input int a, input bit mev, input bit eev,
                    input string tag);
    logic [15:0] e;
    @(negedge clk);
    e = exp_read(v, a);
    req_valid[v] = 1; req_write[v] = 0; req_addr[v] = 18'(a);
    mgmt_event[v] = mev; ext_event[v] = eev;
    @(negedge clk);
    req_valid[v] = 0; mgmt_event[v] = 0; ext_event[v] = 0;
    check(rsp_valid[v] && rsp_rdata[v] == e, tag, 32'(rsp_rdata[v]), 32'(e));
  endtask

  task automatic wr(input int v, input int a, input logic [15:0] d, input string tag);
    @(negedge clk);
    req_valid[v] = 1; req_write[v] = 1; req_addr[v] = 18'(a); req_wdata[v] = d;
    @(negedge clk);
    req_valid[v] = 0; req_write[v] = 0;
    check(rsp_valid[v] && rsp_rdata[v] == 16'h0, tag, 32'(rsp_rdata[v]), 32'h0);
  endtask

  task automatic pulse(input int v, input bit mev, input bit eev);
    @(negedge clk);
    mgmt_event[v] = mev; ext_event[v] = eev;
    @(negedge clk);
    mgmt_event[v] = 0; ext_event[v] = 0;
  endtask

  initial begin
    for (int v = 0; v < 2; v++) begin
      pres[v] = '0; mgmt_event[v] = 0; ext_event[v] = 0; req_valid[v] = 0;
      req_write[v] = 0; req_addr[v] = '0; req_wdata[v] = '0; rsp_ready[v] = 1;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    for (int v = 0; v < 2; v++) begin
      check(!rsp_valid[v] && !mgmt_irq[v] && !ext_irq[v], "R1 reset outputs",
            {29'd0, rsp_valid[v], mgmt_irq[v], ext_irq[v]}, 32'h0);
      rd(v, 'h20008, 0, 0, "R1 mask after reset");
      rd(v, 'h8, 0, 0, "R5 flash protect");
      rd(v, 'hA, 0, 0, "R5 flash size");
      rd(v, 'h30004, 0, 0, "R5 environment");
      rd(v, 'h30000, 0, 0, "R4 platform");
    end

    // R2 narrow presence patterns
    pres[0] = 7'b0000000; rd(0, 'h10006, 0, 0, "R2 none present");
    pres[0] = 7'b0000001; rd(0, 'h10006, 0, 0, "R2 slot0");
    pres[0] = 7'b0001010; rd(0, 'h10006, 0, 0, "R2 slots1,3");
    pres[0] = 7'b1111111; rd(0, 'h10006, 0, 0, "R2 all present");
    // R3 wide presence patterns
    pres[1] = 7'b0000010; rd(1, 'h10006, 0, 0, "R3 slot1 word0");
    rd(1, 'h10008, 0, 0, "R3 word1 empty");
    pres[1] = 7'b0011110; rd(1, 'h10006, 0, 0, "R3 slots1-4 word0");
    pres[1] = 7'b1100001; rd(1, 'h10006, 0, 0, "R3 slot0 ignored");
    rd(1, 'h10008, 0, 0, "R3 slots5,6 word1");
    pres[1] = 7'b0101000; rd(1, 'h10006, 0, 0, "R3 slot3 word0");
    rd(1, 'h10008, 0, 0, "R3 slot5 word1");

    for (int v = 0; v < 2; v++) begin
      // R6 mask read/write, upper bits dropped
      wr(v, 'h20008, 16'h01A5, "R6 mask write");
      rd(v, 'h20008, 0, 0, "R6 mask readback");
      wr(v, 'h20008, 16'hFF3C, "R6 mask rewrite");
      rd(v, 'h20008, 0, 0, "R6 mask readback 2");
      // R7 / R8 acknowledge reads
      pulse(v, 1, 1);
      rd(v, mgmt_off(v), 0, 0, "R7 mgmt ack value");
      rd(v, ext_off(v), 0, 0, "R8 ext ack value");
      // R9 set wins when event and ack coincide
      pulse(v, 1, 1);
      rd(v, mgmt_off(v), 1, 0, "R9 mgmt same-cycle");
      check(mgmt_irq[v] == 1'b1, "R9 mgmt stays set", 32'(mgmt_irq[v]), 32'h1);
      rd(v, ext_off(v), 0, 1, "R9 ext same-cycle");
      check(ext_irq[v] == 1'b1, "R9 ext stays set", 32'(ext_irq[v]), 32'h1);
      // R10 writes do not acknowledge
      wr(v, mgmt_off(v), 16'hFFFF, "R10 write mgmt ack");
      wr(v, ext_off(v), 16'hFFFF, "R10 write ext ack");
      check(mgmt_irq[v] && ext_irq[v], "R10 lines kept",
            {30'd0, mgmt_irq[v], ext_irq[v]}, 32'h3);
      rd(v, mgmt_off(v), 0, 0, "R7 mgmt clear");
      rd(v, ext_off(v), 0, 0, "R8 ext clear");
      check(!mgmt_irq[v] && !ext_irq[v], "R7 R8 lines cleared",
            {30'd0, mgmt_irq[v], ext_irq[v]}, 32'h0);
      // R11 unmapped and read-only
      rd(v, 'h4, 0, 0, "R11 unmapped read");
      rd(v, 'h3FFFF, 0, 0, "R11 unmapped high read");
      wr(v, 'h8, 16'h0000, "R11 write read-only");
      rd(v, 'h8, 0, 0, "R11 read-only unchanged");
      wr(v, 'h1234, 16'h00FF, "R11 write unmapped");
      rd(v, 'h20008, 0, 0, "R11 mask unaffected");
    end
    rd(0, 'h10008, 0, 0, "R11 narrow has no hi presence");

    // R12 back-pressure
    @(negedge clk);
    rsp_ready[0] = 0;
    req_valid[0] = 1; req_write[0] = 0; req_addr[0] = 18'h0000A;
    @(negedge clk);
    req_addr[0] = 18'h30004;
    repeat (2) @(negedge clk);
    check(rsp_valid[0] && rsp_rdata[0] == 16'h1000 && !req_ready[0],
          "R12 held under stall", 32'(rsp_rdata[0]), 32'h1000);
    rsp_ready[0] = 1;
    @(negedge clk);
    req_valid[0] = 0;
    check(rsp_valid[0] && rsp_rdata[0] == 16'h0021, "R12 next beat after release",
          32'(rsp_rdata[0]), 32'h0021);
    repeat (2) @(negedge clk);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule